// File: doc/BRIEF.md
# Out-of-Order Issue Buffer Without Renaming

This block sits between instruction decode and the functional units. It holds a few decoded instructions and sends one per cycle to execution. The instruction it sends is the oldest one whose source operands have been produced, so a younger independent instruction can go ahead of an older one that is still waiting. Register names are not renamed. Because of that, the buffer refuses a new instruction whose destination would overwrite a register that a buffered instruction still has to read. It also refuses one whose destination already has a write outstanding.

A write-pending bit is kept for every architectural register. It is set when an instruction writing that register is accepted and cleared when the register number comes back on the writeback port. Each buffered entry keeps one ready flag per source. The flag is taken from the pending vector at insertion and set by a matching writeback broadcast. A dispatched instruction leaves the buffer at once and has no further effect on insertion. Only its pending write does.

Top module: `ooo_issue_buf`

## Requirements
- R1: After reset the buffer is empty, dis_valid_o is 0, ins_ready_o is 1 and no register has a pending write.
- R2: An instruction is accepted in a cycle where ins_valid_i and ins_ready_o are both 1. ins_ready_o is 0 while all NUM_ENTRIES slots are occupied. A slot freed by a dispatch in the same cycle does not count as free until the next cycle.
- R3: ins_ready_o is 0 while ins_dst_i has a pending write. A write is pending from the acceptance of its writer until a writeback carrying that register number, whether the writer is still buffered or already dispatched.
- R4: ins_ready_o is 0 when ins_dst_i equals src1 or src2 of any instruction still held in the buffer.
- R5: A source is ready at insertion if its register has no pending write, or if a writeback of that register arrives in the same cycle. Otherwise it becomes ready at the clock edge that ends the cycle of the matching writeback.
- R6: dis_valid_o is 1 in every cycle in which at least one held instruction has both sources ready. At most one instruction is dispatched per cycle, and it leaves the buffer at the end of that cycle. An accepted instruction can be dispatched no earlier than the next cycle, even if an older instruction is still waiting.
- R7: When several held instructions are ready, the one accepted earliest is presented on dis_op_o, dis_dst_o, dis_src1_o and dis_src2_o.
- R8: A writeback clears the pending write of its register, so a later instruction writing that register can be accepted once no held instruction reads it. A writeback of a register with no pending write changes nothing.
- R9: Acceptance and dispatch can happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Decode offers an instruction |
| ins_ready_o | output | 1 | Buffer accepts the offered instruction |
| ins_op_i | input | OPC_W | Operation code of the offered instruction |
| ins_dst_i | input | REG_W | Destination register |
| ins_src1_i | input | REG_W | First source register |
| ins_src2_i | input | REG_W | Second source register |
| dis_valid_o | output | 1 | An instruction is dispatched this cycle |
| dis_op_o | output | OPC_W | Operation code of the dispatched instruction |
| dis_dst_o | output | REG_W | Destination of the dispatched instruction |
| dis_src1_o | output | REG_W | First source of the dispatched instruction |
| dis_src2_o | output | REG_W | Second source of the dispatched instruction |
| wb_valid_i | input | 1 | A result is written back this cycle |
| wb_reg_i | input | REG_W | Register number being written back |

## Verification
The hardest state to reach from the ports is a full buffer in which every entry waits on the same producer. After a single writeback, all of them become ready at once and must leave strictly in acceptance order. During that drain, a new instruction must be refused in the dispatch cycle and accepted in the following one. A directed sequence builds this state by holding back one producer's writeback while four readers are inserted. Other directed cycles place a writeback on the exact cycle of an insertion that reads the same register. Constrained random traffic then returns writebacks only for dispatched writers, in random order, with occasional writebacks of idle registers. A cycle-level reference model predicts readiness and the dispatched fields every cycle.

// File: rtl/ooib_pkg.sv
package ooib_pkg;
  parameter int unsigned OPC_W = 4;
  parameter int unsigned REG_W = 4;
  localparam int unsigned NUM_REGS = 1 << REG_W;

  typedef struct packed {
    logic [OPC_W-1:0] op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
  } instr_t;
endpackage

// File: rtl/ooib_pend.sv
module ooib_pend
  import ooib_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [REG_W-1:0]    set_reg_i,
  input  logic                clr_i,
  input  logic [REG_W-1:0]    clr_reg_i,
  output logic [NUM_REGS-1:0] pend_o
);
  logic [NUM_REGS-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d[clr_reg_i] = 1'b0;
    if (set_i) pend_d[set_reg_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // a register never gets a second outstanding writer
  p_single_writer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !pend_q[set_reg_i]);

  p_wb_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(set_i && set_reg_i == clr_reg_i)) |=> !pend_q[$past(clr_reg_i)]);
endmodule

// File: rtl/ooib_slot.sv
module ooib_slot
  import ooib_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  instr_t              instr_i,
  input  logic                rdy1_i,
  input  logic                rdy2_i,
  input  logic                free_i,
  input  logic                wb_valid_i,
  input  logic [REG_W-1:0]    wb_reg_i,
  input  logic [NUM_REGS-1:0] pend_i,
  output logic                valid_o,
  output instr_t              instr_o,
  output logic                ready_o
);
  logic   valid_q, rdy1_q, rdy2_q;
  instr_t ins_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rdy1_q  <= 1'b0;
      rdy2_q  <= 1'b0;
      ins_q   <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      ins_q   <= instr_i;
      rdy1_q  <= rdy1_i;
      rdy2_q  <= rdy2_i;
    end else begin
      if (free_i) valid_q <= 1'b0;
      if (wb_valid_i && wb_reg_i == ins_q.src1) rdy1_q <= 1'b1;
      if (wb_valid_i && wb_reg_i == ins_q.src2) rdy2_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign instr_o = ins_q;
  assign ready_o = valid_q & rdy1_q & rdy2_q;

  // a waiting operand always has its producer recorded as pending
  p_wait_src1_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !rdy1_q) |-> pend_i[ins_q.src1]);
  p_wait_src2_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !rdy2_q) |-> pend_i[ins_q.src2]);
  p_no_alloc_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
endmodule

// File: rtl/ooib_age.sv
module ooib_age #(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] alloc_i,
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic [NUM_ENTRIES-1:0] gnt_o
);
  // older_q[i][j]: entry i was allocated before entry j
  logic [NUM_ENTRIES-1:0] older_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < NUM_ENTRIES; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      gnt_o[i] = req_i[i];
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (j != i && req_i[j] && !older_q[i][j]) gnt_o[i] = 1'b0;
      end
    end
  end

  p_one_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_to_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_grant_when_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/ooo_issue_buf.sv
module ooo_issue_buf
  import ooib_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  output logic             ins_ready_o,
  input  logic [OPC_W-1:0] ins_op_i,
  input  logic [REG_W-1:0] ins_dst_i,
  input  logic [REG_W-1:0] ins_src1_i,
  input  logic [REG_W-1:0] ins_src2_i,
  output logic             dis_valid_o,
  output logic [OPC_W-1:0] dis_op_o,
  output logic [REG_W-1:0] dis_dst_o,
  output logic [REG_W-1:0] dis_src1_o,
  output logic [REG_W-1:0] dis_src2_o,
  input  logic             wb_valid_i,
  input  logic [REG_W-1:0] wb_reg_i
);
  logic [NUM_ENTRIES-1:0] slot_vld, slot_rdy, alloc, alloc_pick, gnt, war_hit;
  instr_t                 slot_ins [NUM_ENTRIES];
  instr_t                 new_ins, dis_ins;
  logic [NUM_REGS-1:0]    pend;
  logic                   has_free, ins_fire, new_rdy1, new_rdy2;

  assign new_ins = {ins_op_i, ins_dst_i, ins_src1_i, ins_src2_i};

  // lowest free slot
  always_comb begin
    alloc_pick = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!slot_vld[i]) alloc_pick = NUM_ENTRIES'(1) << i;
    end
  end

  assign has_free = ~&slot_vld;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_war
    assign war_hit[g] = slot_vld[g] &&
                        (slot_ins[g].src1 == ins_dst_i || slot_ins[g].src2 == ins_dst_i);
  end

  assign ins_ready_o = has_free && !pend[ins_dst_i] && !(|war_hit);
  assign ins_fire    = ins_valid_i && ins_ready_o;
  assign alloc       = ins_fire ? alloc_pick : '0;

  assign new_rdy1 = !pend[ins_src1_i] || (wb_valid_i && wb_reg_i == ins_src1_i);
  assign new_rdy2 = !pend[ins_src2_i] || (wb_valid_i && wb_reg_i == ins_src2_i);

  ooib_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ins_fire),
    .set_reg_i (ins_dst_i),
    .clr_i     (wb_valid_i),
    .clr_reg_i (wb_reg_i),
    .pend_o    (pend)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    ooib_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc[g]),
      .instr_i    (new_ins),
      .rdy1_i     (new_rdy1),
      .rdy2_i     (new_rdy2),
      .free_i     (gnt[g]),
      .wb_valid_i (wb_valid_i),
      .wb_reg_i   (wb_reg_i),
      .pend_i     (pend),
      .valid_o    (slot_vld[g]),
      .instr_o    (slot_ins[g]),
      .ready_o    (slot_rdy[g])
    );
  end

  ooib_age #(.NUM_ENTRIES(NUM_ENTRIES)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc),
    .req_i   (slot_rdy),
    .gnt_o   (gnt)
  );

  always_comb begin
    dis_ins = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (gnt[i]) dis_ins = dis_ins | slot_ins[i];
    end
  end

  assign dis_valid_o = |gnt;
  assign dis_op_o    = dis_ins.op;
  assign dis_dst_o   = dis_ins.dst;
  assign dis_src1_o  = dis_ins.src1;
  assign dis_src2_o  = dis_ins.src2;

  // dispatched operands have no outstanding writer other than the instruction itself
  p_dis_src_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_valid_o |-> ((dis_src1_o == dis_dst_o || !pend[dis_src1_o]) &&
                     (dis_src2_o == dis_dst_o || !pend[dis_src2_o])));
  p_dis_dst_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_valid_o |-> pend[dis_dst_o]);
endmodule

// File: tb/tb_ooo_issue_buf.sv
module tb_ooo_issue_buf;
  localparam int NE = 4;
  localparam int RW = 4;
  localparam int OW = 4;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  logic rst_ni;
  always #4 clk = ~clk;

  logic          ins_valid_i, wb_valid_i;
  logic [OW-1:0] ins_op_i;
  logic [RW-1:0] ins_dst_i, ins_src1_i, ins_src2_i, wb_reg_i;
  logic          ins_ready_o, dis_valid_o;
  logic [OW-1:0] dis_op_o;
  logic [RW-1:0] dis_dst_o, dis_src1_o, dis_src2_o;

  ooo_issue_buf #(.NUM_ENTRIES(NE)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid_i), .ins_ready_o(ins_ready_o), .ins_op_i(ins_op_i),
    .ins_dst_i(ins_dst_i), .ins_src1_i(ins_src1_i), .ins_src2_i(ins_src2_i),
    .dis_valid_o(dis_valid_o), .dis_op_o(dis_op_o), .dis_dst_o(dis_dst_o),
    .dis_src1_o(dis_src1_o), .dis_src2_o(dis_src2_o),
    .wb_valid_i(wb_valid_i), .wb_reg_i(wb_reg_i)
  );

  int n_chk = 0, n_bad = 0;

  // reference model
  bit            mv [NE];
  int            mseq [NE];
  logic [OW-1:0] mop [NE];
  logic [RW-1:0] md [NE], ms1 [NE], ms2 [NE];
  bit            mr1 [NE], mr2 [NE];
  bit            mpend [NR];
  bit            mfly [NR];
  int            seqc = 0;

  bit            obs_rdy, obs_dv;
  logic [RW-1:0] obs_dd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int free_idx();
    for (int i = 0; i < NE; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  function automatic bit war_any();
    for (int i = 0; i < NE; i++)
      if (mv[i] && (ms1[i] == ins_dst_i || ms2[i] == ins_dst_i)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_ready();
    return free_idx() >= 0 && !mpend[ins_dst_i] && !war_any();
  endfunction

  function automatic int exp_pick();
    int p = -1;
    for (int i = 0; i < NE; i++)
      if (mv[i] && mr1[i] && mr2[i] && (p < 0 || mseq[i] < mseq[p])) p = i;
    return p;
  endfunction

  task automatic step();
    bit    er;
    int    p, f;
    string rtag;
    bit    n1, n2;
    #1;
    er = exp_ready();
    p  = exp_pick();
    f  = free_idx();
    if (f < 0)                     rtag = "R2 ins_ready full";
    else if (mpend[ins_dst_i])     rtag = "R3 ins_ready waw";
    else if (war_any())            rtag = "R4 ins_ready war";
    else                           rtag = "R2 ins_ready";
    chk(rtag, 32'(ins_ready_o), 32'(er));
    chk("R6 dis_valid", 32'(dis_valid_o), 32'(p >= 0));
    if (p >= 0) begin
      chk("R7 dis_op",   32'(dis_op_o),   32'(mop[p]));
      chk("R7 dis_dst",  32'(dis_dst_o),  32'(md[p]));
      chk("R7 dis_src1", 32'(dis_src1_o), 32'(ms1[p]));
      chk("R7 dis_src2", 32'(dis_src2_o), 32'(ms2[p]));
    end
    obs_rdy = ins_ready_o;
    obs_dv  = dis_valid_o;
    obs_dd  = dis_dst_o;
    @(posedge clk);
    n1 = !mpend[ins_src1_i] || (wb_valid_i && wb_reg_i == ins_src1_i);
    n2 = !mpend[ins_src2_i] || (wb_valid_i && wb_reg_i == ins_src2_i);
    if (wb_valid_i) begin
      for (int i = 0; i < NE; i++) begin
        if (mv[i] && ms1[i] == wb_reg_i) mr1[i] = 1'b1;
        if (mv[i] && ms2[i] == wb_reg_i) mr2[i] = 1'b1;
      end
    end
    if (p >= 0) begin
      mv[p] = 1'b0;
      mfly[md[p]] = 1'b1;
    end
    if (wb_valid_i) begin
      mpend[wb_reg_i] = 1'b0;
      mfly[wb_reg_i]  = 1'b0;
    end
    if (ins_valid_i && er) begin
      mv[f] = 1'b1; mseq[f] = seqc++; mop[f] = ins_op_i; md[f] = ins_dst_i;
      ms1[f] = ins_src1_i; ms2[f] = ins_src2_i; mr1[f] = n1; mr2[f] = n2;
      mpend[ins_dst_i] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic cyc(bit iv, int d, int s1, int s2, bit wv, int wr);
    ins_valid_i = iv;
    ins_op_i    = OW'(d);
    ins_dst_i   = RW'(d);
    ins_src1_i  = RW'(s1);
    ins_src2_i  = RW'(s2);
    wb_valid_i  = wv;
    wb_reg_i    = RW'(wr);
    step();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    ins_valid_i = 0; ins_op_i = 0; ins_dst_i = 0; ins_src1_i = 0; ins_src2_i = 0;
    wb_valid_i = 0; wb_reg_i = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset", 32'(ins_ready_o), 32'd1);
    chk("R1 no dispatch in reset", 32'(dis_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    cyc(1, 1, 2, 3, 0, 0);
    chk("R1 empty after reset", 32'(obs_dv), 32'd0);
    cyc(1, 4, 1, 0, 0, 0);
    chk("R6 next-cycle dispatch", 32'(obs_dd), 32'd1);
    cyc(1, 5, 1, 1, 0, 0);
    cyc(1, 6, 0, 0, 0, 0);
    chk("R5 waiting source holds", 32'(obs_dv), 32'd0);
    cyc(1, 1, 7, 7, 0, 0);
    chk("R3 waw blocked", 32'(obs_rdy), 32'd0);
    chk("R6 younger ready goes first", 32'(obs_dd), 32'd6);
    cyc(1, 0, 7, 7, 1, 1);
    chk("R4 war blocked", 32'(obs_rdy), 32'd0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 oldest of ready", 32'(obs_dd), 32'd4);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 next oldest", 32'(obs_dd), 32'd5);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R8 dst free after wb", 32'(obs_rdy), 32'd1);
    cyc(0, 0, 0, 0, 1, 9);
    chk("R8 idle wb no effect", 32'({obs_dv, obs_dd}), 32'({1'b1, 4'd1}));
    cyc(1, 7, 4, 4, 1, 4);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R5 same-cycle wb ready", 32'({obs_dv, obs_dd}), 32'({1'b1, 4'd7}));
    for (int d = 8; d < 12; d++) cyc(1, d, 5, 5, 0, 0);
    cyc(1, 12, 0, 0, 0, 0);
    chk("R2 full blocks", 32'(obs_rdy), 32'd0);
    cyc(1, 12, 0, 0, 1, 5);
    cyc(1, 12, 0, 0, 0, 0);
    chk("R2 dispatch slot not yet free", 32'(obs_rdy), 32'd0);
    chk("R7 drain order 8", 32'(obs_dd), 32'd8);
    cyc(1, 12, 0, 0, 0, 0);
    chk("R9 insert with dispatch", 32'({obs_rdy, obs_dv}), 32'd3);
    chk("R7 drain order 9", 32'(obs_dd), 32'd9);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 drain order 10", 32'(obs_dd), 32'd10);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 drain order 11", 32'(obs_dd), 32'd11);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 drain order 12", 32'(obs_dd), 32'd12);
    for (int r = 0; r < NR; r++) if (mfly[r]) cyc(0, 0, 0, 0, 1, r);

    for (int n = 0; n < 3000; n++) begin
      bit wv = 1'b0;
      int wr = 0;
      if ($urandom % 3 == 0) begin
        int st = int'($urandom % NR);
        for (int k = 0; k < NR; k++) begin
          if (!wv && mfly[(st + k) % NR]) begin wv = 1'b1; wr = (st + k) % NR; end
        end
      end else if ($urandom % 20 == 0) begin
        int r = int'($urandom % NR);
        if (!mpend[r]) begin wv = 1'b1; wr = r; end
      end
      ins_valid_i = ($urandom % 4) != 0;
      ins_op_i    = OW'($urandom);
      ins_dst_i   = RW'($urandom);
      ins_src1_i  = RW'($urandom);
      ins_src2_i  = RW'($urandom);
      wb_valid_i  = wv;
      wb_reg_i    = RW'(wr);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule